// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small set of one-bit ownership tokens shared between two independent ports, a left and a right one. Software on either side uses a token to mark a shared resource as taken: it writes a 0 to ask for the token and a 1 to give it back. A read tells the port whether it currently holds the selected token. Each access is qualified by an active-low select strobe. The select path is separate from any ordinary memory path. The token is chosen by a small index.

Ownership is kept per port, so the unit never lets both sides hold the same token. A request that finds the token taken by the other side is not dropped. It is remembered, and the port receives the token automatically once the holder lets go. Both ports are sampled on one clock edge. Register updates take effect after the edge.

Top module: `sem_token_unit`

## Requirements
- R1: After reset every token is free and no request is pending. Both ports then read all ones (8'hFF) for every index, and a request that was pending before the reset is never granted afterwards.
- R2: A port affects no token while its select `*_sel_n` is high. A selected access with `*_wr` low is a read and changes no token. The index `*_idx[2:0]` picks one of eight tokens.
- R3: No token is held by both ports at once.
- R4: A selected write with `*_din` = 0 to a free token gives that port the token from the next cycle. A port that holds the indexed token reads 8'h00, and any other port reads 8'hFF.
- R5: A selected write with `*_din` = 1 frees a token held by the writing port from the next cycle. It has no effect on a token the port does not hold. A holder keeps its token until it releases it.
- R6: A request for a token held by the other port stays pending. The token becomes free in the cycle after the release write and is granted to the waiting port one cycle later. During that free cycle the pending request outranks a fresh request from the port that released.
- R7: When both ports request the same free token in one cycle with nothing pending, the left port gets it and the right request stays pending.
- R8: Tokens are independent: an access to one index never changes the ownership of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_idx | input | 3 | Left token index |
| l_din | input | 1 | Left write data: 0 request, 1 release |
| l_dout | output | 8 | Left status: 8'h00 when left holds the indexed token, else 8'hFF |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_idx | input | 3 | Right token index |
| r_din | input | 1 | Right write data: 0 request, 1 release |
| r_dout | output | 8 | Right status: 8'h00 when right holds the indexed token, else 8'hFF |

## Verification
On every cycle the assertions check, for each token, these properties:
- no token has two holders;
- a grant always has a request or a pending request behind it;
- a holder keeps its token until it writes a release;
- a release with the other side waiting leads to the hand-off two cycles later;
- a tie on a free token goes to the left side.

Some behaviour shows only in the bench scenarios at the ports:
- the status words each side reads;
- writes that are ignored because the select is high, or that are reads;
- release writes from a port that does not hold the token;
- the pending request outranking a fresh one in the free cycle;
- the loss of pending state on reset.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // Default geometry of the unit
  localparam int unsigned SEM_TOKENS = 8;
  localparam int unsigned SEM_DATA_W = 8;

  // A selected write carrying 0 asks for a token
  function automatic logic is_claim(input logic sel_n, input logic wr, input logic din);
    return !sel_n && wr && !din;
  endfunction

  // A selected write carrying 1 gives a token back
  function automatic logic is_drop(input logic sel_n, input logic wr, input logic din);
    return !sel_n && wr && din;
  endfunction
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
#(
  parameter int unsigned NUM_TOK = SEM_TOKENS,
  localparam int unsigned IDX_W = $clog2(NUM_TOK)
) (
  input  logic               sel_n,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic               din,
  output logic [NUM_TOK-1:0] claim,
  output logic [NUM_TOK-1:0] drop
);
  logic claim_any;
  logic drop_any;

  assign claim_any = is_claim(sel_n, wr, din);
  assign drop_any  = is_drop(sel_n, wr, din);

  for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
    assign claim[t] = claim_any && (idx == IDX_W'(t));
    assign drop[t]  = drop_any  && (idx == IDX_W'(t));
  end
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic claim_l,
  input  logic drop_l,
  input  logic claim_r,
  input  logic drop_r,
  output logic own_l,
  output logic own_r,
  output logic wait_l,
  output logic wait_r
);
  logic is_free;
  logic gnt_l;
  logic gnt_r;

  assign is_free = !own_l && !own_r;
  // Waiting requests outrank fresh ones; among fresh ones left wins
  assign gnt_l = is_free && (wait_l || (claim_l && !wait_r));
  assign gnt_r = is_free && !gnt_l && (wait_r || claim_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_l  <= 1'b0;
      own_r  <= 1'b0;
      wait_l <= 1'b0;
      wait_r <= 1'b0;
    end else begin
      own_l  <= gnt_l || (own_l && !drop_l);
      own_r  <= gnt_r || (own_r && !drop_r);
      wait_l <= !gnt_l && (wait_l || (claim_l && !own_l));
      wait_r <= !gnt_r && (wait_r || (claim_r && !own_r));
    end
  end
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit
  import sem_pkg::*;
#(
  parameter int unsigned NUM_TOK = SEM_TOKENS,
  parameter int unsigned DATA_W  = SEM_DATA_W,
  localparam int unsigned IDX_W  = $clog2(NUM_TOK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_wr,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              r_sel_n,
  input  logic              r_wr,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_din,
  output logic [DATA_W-1:0] r_dout
);
  // Named internal events, visible to the bound checker
  logic [NUM_TOK-1:0] claim_l, drop_l, claim_r, drop_r;
  logic [NUM_TOK-1:0] own_l, own_r, wait_l, wait_r;

  function automatic logic [DATA_W-1:0] status_word(input logic held);
    return {DATA_W{!held}};
  endfunction

  sem_port_decode #(.NUM_TOK(NUM_TOK)) i_dec_l (
    .sel_n(l_sel_n), .wr(l_wr), .idx(l_idx), .din(l_din),
    .claim(claim_l), .drop(drop_l)
  );

  sem_port_decode #(.NUM_TOK(NUM_TOK)) i_dec_r (
    .sel_n(r_sel_n), .wr(r_wr), .idx(r_idx), .din(r_din),
    .claim(claim_r), .drop(drop_r)
  );

  for (genvar t = 0; t < NUM_TOK; t++) begin : g_cell
    sem_token_cell i_cell (
      .clk(clk), .rst_n(rst_n),
      .claim_l(claim_l[t]), .drop_l(drop_l[t]),
      .claim_r(claim_r[t]), .drop_r(drop_r[t]),
      .own_l(own_l[t]), .own_r(own_r[t]),
      .wait_l(wait_l[t]), .wait_r(wait_r[t])
    );
  end

  assign l_dout = status_word(own_l[l_idx]);
  assign r_dout = status_word(own_r[r_idx]);
endmodule

// File: rtl/sem_token_chk.sv
module sem_token_chk #(
  parameter int unsigned NUM_TOK = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_TOK-1:0] claim_l,
  input logic [NUM_TOK-1:0] drop_l,
  input logic [NUM_TOK-1:0] claim_r,
  input logic [NUM_TOK-1:0] drop_r,
  input logic [NUM_TOK-1:0] own_l,
  input logic [NUM_TOK-1:0] own_r,
  input logic [NUM_TOK-1:0] wait_l,
  input logic [NUM_TOK-1:0] wait_r
);
  AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0); // R3

  for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
    AST_LEFT_GRANT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_l[t]) |-> $past(claim_l[t] || wait_l[t])); // R4
    AST_RIGHT_GRANT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_r[t]) |-> $past(claim_r[t] || wait_r[t])); // R4
    AST_LEFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[t] && !drop_l[t] |=> own_l[t]); // R5
    AST_RIGHT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      own_r[t] && !drop_r[t] |=> own_r[t]); // R5
    AST_HANDOFF_TO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[t] && drop_l[t] && wait_r[t] |=> !own_l[t] ##1 own_r[t]); // R6
    AST_HANDOFF_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      own_r[t] && drop_r[t] && wait_l[t] |=> !own_r[t] ##1 own_l[t]); // R6
    AST_TIE_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      !own_l[t] && !own_r[t] && !wait_l[t] && !wait_r[t] && claim_l[t] && claim_r[t]
      |=> own_l[t] && wait_r[t]); // R7
  end
endmodule

bind sem_token_unit sem_token_chk #(.NUM_TOK(NUM_TOK)) i_sem_token_chk (
  .clk(clk), .rst_n(rst_n),
  .claim_l(claim_l), .drop_l(drop_l), .claim_r(claim_r), .drop_r(drop_r),
  .own_l(own_l), .own_r(own_r), .wait_l(wait_l), .wait_r(wait_r)
);

// File: tb/test_sem_token_unit.sv
module test_sem_token_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_sel_n = 1'b1, l_wr = 1'b0, l_din = 1'b1;
  logic [2:0] l_idx = 3'd0;
  logic       r_sel_n = 1'b1, r_wr = 1'b0, r_din = 1'b1;
  logic [2:0] r_idx = 3'd0;
  logic [7:0] l_dout, r_dout;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_token_unit i_sem_token_unit (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_wr(l_wr), .l_idx(l_idx), .l_din(l_din), .l_dout(l_dout),
    .r_sel_n(r_sel_n), .r_wr(r_wr), .r_idx(r_idx), .r_din(r_din), .r_dout(r_dout)
  );

  typedef struct packed {
    logic       lsel_n; logic lwr; logic [2:0] lidx; logic ldin;
    logic       rsel_n; logic rwr; logic [2:0] ridx; logic rdin;
    logic [2:0] chk;    logic el;  logic er;
  } vec_t;

  // One access cycle per entry, then the ownership of token chk is checked
  localparam vec_t VEC [16] = '{
    '{1'b0,1'b1,3'd3,1'b0, 1'b1,1'b0,3'd0,1'b1, 3'd3,1'b1,1'b0}, // R4 left claims 3
    '{1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd3,1'b0, 3'd3,1'b1,1'b0}, // R3 right waits on 3
    '{1'b0,1'b1,3'd3,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd3,1'b0,1'b0}, // R6 free cycle
    '{1'b1,1'b0,3'd0,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd3,1'b0,1'b1}, // R6 handed to right
    '{1'b0,1'b1,3'd3,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd3,1'b0,1'b1}, // R5 non-holder release
    '{1'b0,1'b1,3'd5,1'b0, 1'b0,1'b1,3'd5,1'b0, 3'd5,1'b1,1'b0}, // R7 tie
    '{1'b0,1'b1,3'd5,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd5,1'b0,1'b0}, // R7 release
    '{1'b1,1'b0,3'd0,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd5,1'b0,1'b1}, // R7 right waited
    '{1'b1,1'b0,3'd0,1'b1, 1'b1,1'b1,3'd0,1'b0, 3'd0,1'b0,1'b0}, // R2 unselected write
    '{1'b0,1'b0,3'd0,1'b0, 1'b1,1'b0,3'd0,1'b1, 3'd0,1'b0,1'b0}, // R2 read, no claim
    '{1'b0,1'b1,3'd7,1'b0, 1'b0,1'b1,3'd6,1'b0, 3'd7,1'b1,1'b0}, // R8 two tokens
    '{1'b1,1'b0,3'd0,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd6,1'b0,1'b1}, // R8 other token
    '{1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd6,1'b1, 3'd6,1'b0,1'b0}, // R5 right releases 6
    '{1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd3,1'b1, 3'd3,1'b0,1'b0}, // R5 right releases 3
    '{1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd5,1'b1, 3'd5,1'b0,1'b0}, // R5 right releases 5
    '{1'b0,1'b1,3'd7,1'b1, 1'b1,1'b0,3'd0,1'b1, 3'd7,1'b0,1'b0}  // R5 left releases 7
  };

  task automatic drive(input logic ls, input logic lw, input logic [2:0] li, input logic ld,
                       input logic rs, input logic rw, input logic [2:0] ri, input logic rd);
    l_sel_n = ls; l_wr = lw; l_idx = li; l_din = ld;
    r_sel_n = rs; r_wr = rw; r_idx = ri; r_din = rd;
  endtask

  task automatic step(input logic ls, input logic lw, input logic [2:0] li, input logic ld,
                      input logic rs, input logic rw, input logic [2:0] ri, input logic rd);
    drive(ls, lw, li, ld, rs, rw, ri, rd);
    @(posedge clk);
    @(negedge clk);
    drive(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1);
  endtask

  task automatic check_tok(input logic [2:0] t, input logic el, input logic er, input string req);
    logic [7:0] exp_l, exp_r;
    l_idx = t; r_idx = t;
    #1;
    exp_l = el ? 8'h00 : 8'hFF;
    exp_r = er ? 8'h00 : 8'hFF;
    n_cmp += 2;
    if (l_dout !== exp_l) begin
      n_bad++;
      $display("FAIL %s left token %0d: got %h expected %h", req, t, l_dout, exp_l);
    end
    if (r_dout !== exp_r) begin
      n_bad++;
      $display("FAIL %s right token %0d: got %h expected %h", req, t, r_dout, exp_r);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 2);
    for (int t = 0; t < 8; t++) check_tok(3'(t), 1'b0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int i = 0; i < 16; i++) begin
      step(VEC[i].lsel_n, VEC[i].lwr, VEC[i].lidx, VEC[i].ldin,
           VEC[i].rsel_n, VEC[i].rwr, VEC[i].ridx, VEC[i].rdin);
      check_tok(VEC[i].chk, VEC[i].el, VEC[i].er, $sformatf("R%0s vec%0d", "4-8", i));
    end

    // R6: a waiting request beats a fresh one from the releasing port
    step(1'b0,1'b1,3'd1,1'b0, 1'b1,1'b0,3'd0,1'b1);
    step(1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd1,1'b0);
    step(1'b0,1'b1,3'd1,1'b1, 1'b1,1'b0,3'd0,1'b1);
    step(1'b0,1'b1,3'd1,1'b0, 1'b1,1'b0,3'd0,1'b1);
    check_tok(3'd1, 1'b0, 1'b1, "R6 waiting priority");
    step(1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd1,1'b1);
    step(1'b1,1'b0,3'd0,1'b1, 1'b1,1'b0,3'd0,1'b1);
    check_tok(3'd1, 1'b1, 1'b0, "R6 left waited");

    // R1: reset drops ownership and a waiting request
    step(1'b1,1'b0,3'd0,1'b1, 1'b0,1'b1,3'd1,1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1,1'b0,3'd0,1'b1, 1'b1,1'b0,3'd0,1'b1);
    step(1'b1,1'b0,3'd0,1'b1, 1'b1,1'b0,3'd0,1'b1);
    check_tok(3'd1, 1'b0, 1'b0, "R1 after reset");
    for (int t = 0; t < 8; t++) check_tok(3'(t), 1'b0, 1'b0, "R1 all free");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule